// File: doc/BRIEF.md
# 8-bit ALU Execute Stage

This block is the execute stage of an 8-bit RISC core for register-register and register-immediate arithmetic and logic. Each clock it takes a 16-bit instruction word and the two operand bytes the register file read for it. It returns the result byte, a write-enable for the destination register and the status flags. Add, subtract and compare exist in plain and carry-chained forms, so wider numbers can be processed one byte per instruction. The carry and zero flags from the previous byte feed the next byte.

The flags live in a six-bit status register inside the block. Its value is the `status` output. The encoding is fixed: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 sign, bit 5 half-carry. The register file outside selects the destination register from the instruction word. The block only says whether a write happens and what value it writes.

Top module: `alu8_exec`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `wr_en` is 0 and `status` is 0. Status bit order is [0] carry C, [1] zero Z, [2] negative N, [3] overflow V, [4] sign S, [5] half-carry H.
- R2: Every instruction completes in one cycle. The `result`, `wr_en` and `status` for the word on `opcode` appear after the next rising clock edge and stay constant until the edge after that.
- R3: The register-register add forms have bits 15:14 = 00. Bits 13:10 = 0011 adds with no carry in. Bits 13:10 = 0111 also adds the stored C. For both, `result` is op_d + op_r (+C) and `wr_en` is 1. C is the carry out of bit 7, H is the carry out of bit 3, and V flags two's-complement overflow.
- R4: The subtract forms compute op_d − operand (−C) and set `wr_en` to 1. Register forms are bits 15:10 = 000110 (no borrow in) and 000010 (stored C as borrow in). Immediate forms are bits 15:12 = 0101 (no borrow in) and 0100 (borrow in). C is the borrow out of bit 7, H is the borrow out of bit 3, and V flags two's-complement overflow.
- R5: The compare forms never assert `wr_en`. They set C, Z, N, V, S and H exactly as the matching subtract would. The forms are bits 15:10 = 000101 (compare), 000001 (compare with carry) and bits 15:12 = 0011 (compare with immediate).
- R6: In the borrow-in forms (bits 15:10 = 000010, 000001, and bits 15:12 = 0100), Z becomes 1 only when the result is zero and Z was already 1. Otherwise Z clears. In all other flag-updating forms, Z is 1 exactly when the 8-bit result is zero.
- R7: In every flag-updating form, N equals bit 7 of the result and S equals N XOR V.
- R8: The logic forms write the result, clear V and keep C and H unchanged. They are: bits 15:10 = 001000 AND, 001001 XOR, 001010 OR, and bits 15:12 = 0111 AND-immediate, 0110 OR-immediate.
- R9: Bits 15:10 = 001011 copies op_r to `result` with `wr_en` 1 and changes no flag.
- R10: In the immediate forms (bits 15:12 = 0011 to 0111), the second operand is the constant {opcode[11:8], opcode[3:0]} and `op_r` is ignored. In register forms, op_r is the second operand.
- R11: Any instruction word outside the forms above gives `wr_en` 0 and leaves `status` unchanged. This includes all words with bit 15 set and bits 15:10 = 000000 or 000100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 16 | Instruction word executed this cycle |
| op_d | input | 8 | Destination/first operand register value |
| op_r | input | 8 | Source register value (second operand in register forms) |
| result | output | 8 | Registered result byte |
| wr_en | output | 1 | Registered destination write-enable |
| status | output | 6 | Stored flags {H,S,V,N,Z,C} |

## Verification
The assertions watch the instruction word and the outputs every cycle. They check these properties:
- Compares never write.
- A borrow-chained subtract or compare never raises Z.
- S always matches N XOR V.
- Logic forms keep C and H and clear V.
- The copy form and any unknown word leave the flags alone.

The bench's reference model is needed for the numeric side: the result values, carry, half-carry and overflow on the edge cases such as 0x7F+1, 0x0F+1 and 0x00−1. It also covers multi-byte chains whose carry and zero flags cross from one instruction to the next, and the proof that op_r is ignored in the immediate forms.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 16;

  typedef enum logic [2:0] {
    FN_NONE, FN_ADD, FN_SUB, FN_AND, FN_XOR, FN_OR, FN_COPY
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e             fn;
    logic                use_carry;
    logic                writes;
    logic                imm_sel;
    logic [DATA_W-1:0]   kimm;
  } decoded_t;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } status_t;

  typedef struct packed {
    logic [DATA_W-1:0] r;
    logic              c;
    logic              h;
    logic              v;
  } arith_t;

  function automatic arith_t add_bytes(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b,
                                       input logic cin);
    arith_t o;
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;
    full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    low  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    o.r = full[DATA_W-1:0];
    o.c = full[DATA_W];
    o.h = low[NIB_W];
    o.v = (a[DATA_W-1] == b[DATA_W-1]) && (o.r[DATA_W-1] != a[DATA_W-1]);
    return o;
  endfunction

  function automatic arith_t sub_bytes(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b,
                                       input logic bin);
    arith_t o;
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;
    full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
    low  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, bin};
    o.r = full[DATA_W-1:0];
    o.c = full[DATA_W];
    o.h = low[NIB_W];
    o.v = (a[DATA_W-1] != b[DATA_W-1]) && (o.r[DATA_W-1] != a[DATA_W-1]);
    return o;
  endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [7:0] op_hi,
  input  logic [3:0] op_lo,
  output decoded_t   dec
);

  logic [1:0] sub_sel;
  assign sub_sel = op_hi[3:2];

  always_comb begin
    dec           = '0;
    dec.fn        = FN_NONE;
    dec.kimm      = {op_hi[3:0], op_lo};
    unique case (op_hi[7:4])
      4'b0000: begin
        case (sub_sel)
          2'b01:   begin dec.fn = FN_SUB; dec.use_carry = 1'b1; end
          2'b10:   begin dec.fn = FN_SUB; dec.use_carry = 1'b1; dec.writes = 1'b1; end
          2'b11:   begin dec.fn = FN_ADD; dec.writes = 1'b1; end
          default: dec.fn = FN_NONE;
        endcase
      end
      4'b0001: begin
        case (sub_sel)
          2'b01:   dec.fn = FN_SUB;
          2'b10:   begin dec.fn = FN_SUB; dec.writes = 1'b1; end
          2'b11:   begin dec.fn = FN_ADD; dec.use_carry = 1'b1; dec.writes = 1'b1; end
          default: dec.fn = FN_NONE;
        endcase
      end
      4'b0010: begin
        dec.writes = 1'b1;
        case (sub_sel)
          2'b00:   dec.fn = FN_AND;
          2'b01:   dec.fn = FN_XOR;
          2'b10:   dec.fn = FN_OR;
          default: dec.fn = FN_COPY;
        endcase
      end
      4'b0011: begin dec.fn = FN_SUB; dec.imm_sel = 1'b1; end
      4'b0100: begin dec.fn = FN_SUB; dec.imm_sel = 1'b1; dec.use_carry = 1'b1; dec.writes = 1'b1; end
      4'b0101: begin dec.fn = FN_SUB; dec.imm_sel = 1'b1; dec.writes = 1'b1; end
      4'b0110: begin dec.fn = FN_OR;  dec.imm_sel = 1'b1; dec.writes = 1'b1; end
      4'b0111: begin dec.fn = FN_AND; dec.imm_sel = 1'b1; dec.writes = 1'b1; end
      default: dec.fn = FN_NONE;
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  decoded_t            dec,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b_reg,
  input  status_t             st,
  output logic [DATA_W-1:0]   res,
  output logic                wr,
  output status_t             st_next,
  output logic                flag_upd
);

  logic [DATA_W-1:0] b;
  logic              cin;
  arith_t            sum_o;
  arith_t            dif_o;
  logic              res_zero;

  assign b     = dec.imm_sel ? dec.kimm : b_reg;
  assign cin   = dec.use_carry & st.c;
  assign sum_o = add_bytes(a, b, cin);
  assign dif_o = sub_bytes(a, b, cin);

  always_comb begin
    case (dec.fn)
      FN_ADD:  res = sum_o.r;
      FN_SUB:  res = dif_o.r;
      FN_AND:  res = a & b;
      FN_XOR:  res = a ^ b;
      FN_OR:   res = a | b;
      FN_COPY: res = b;
      default: res = '0;
    endcase
  end

  assign res_zero = (res == '0);
  assign wr       = dec.writes;
  assign flag_upd = (dec.fn != FN_NONE) && (dec.fn != FN_COPY);

  always_comb begin
    st_next = st;
    case (dec.fn)
      FN_ADD: begin
        st_next.c = sum_o.c;
        st_next.h = sum_o.h;
        st_next.v = sum_o.v;
        st_next.z = res_zero;
      end
      FN_SUB: begin
        st_next.c = dif_o.c;
        st_next.h = dif_o.h;
        st_next.v = dif_o.v;
        st_next.z = res_zero & (~dec.use_carry | st.z);
      end
      FN_AND, FN_XOR, FN_OR: begin
        st_next.v = 1'b0;
        st_next.z = res_zero;
      end
      default: st_next = st;
    endcase
    if (flag_upd) begin
      st_next.n = res[DATA_W-1];
      st_next.s = res[DATA_W-1] ^ st_next.v;
    end
  end

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] op_d,
  input  logic [DATA_W-1:0] op_r,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [5:0]        status
);

  decoded_t          dec;
  status_t           st_q;
  status_t           st_next;
  logic [DATA_W-1:0] res_c;
  logic              wr_c;
  logic              flag_upd;
  logic              unused_dst_idx;

  // destination index bits are decoded by the register file, not here
  assign unused_dst_idx = ^opcode[7:4];

  alu8_decode u_decode (
    .op_hi (opcode[15:8]),
    .op_lo (opcode[3:0]),
    .dec   (dec)
  );

  alu8_core u_core (
    .dec      (dec),
    .a        (op_d),
    .b_reg    (op_r),
    .st       (st_q),
    .res      (res_c),
    .wr       (wr_c),
    .st_next  (st_next),
    .flag_upd (flag_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      st_q   <= '0;
    end else begin
      result <= res_c;
      wr_en  <= wr_c;
      st_q   <= st_next;
    end
  end

  assign status = st_q;

  // event wires for the assertions, taken straight from the instruction word
  logic is_compare, is_chain_sub, is_logic, is_copy, is_foreign;
  assign is_compare   = (opcode[15:10] == 6'b000101) || (opcode[15:10] == 6'b000001)
                      || (opcode[15:12] == 4'b0011);
  assign is_chain_sub = (opcode[15:10] == 6'b000010) || (opcode[15:10] == 6'b000001)
                      || (opcode[15:12] == 4'b0100);
  assign is_logic     = ((opcode[15:12] == 4'b0010) && (opcode[11:10] != 2'b11))
                      || (opcode[15:13] == 3'b011);
  assign is_copy      = (opcode[15:10] == 6'b001011);
  assign is_foreign   = opcode[15] || (opcode[15:10] == 6'b000000)
                      || (opcode[15:10] == 6'b000100);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    is_compare |=> !wr_en); // R5

  AST_CHAIN_Z_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chain_sub && !status[1]) |=> !status[1]); // R6

  AST_SIGN_IS_N_XOR_V: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == (status[2] ^ status[3])); // R7

  AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> (!status[3] && $stable(status[0]) && $stable(status[5]))); // R8

  AST_COPY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    is_copy |=> (wr_en && $stable(status))); // R9

  AST_FOREIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_foreign |=> (!wr_en && $stable(status))); // R11

  AST_N_TRACKS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && wr_c) |=> (status[2] == result[DATA_W-1])); // R7

endmodule

// File: tb/test_alu8_exec.sv
module test_alu8_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [7:0]  op_d = 8'h00;
  logic [7:0]  op_r = 8'h00;
  logic [7:0]  result;
  logic        wr_en;
  logic [5:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference flags
  bit mc, mz, mn, mv, ms, mh;

  alu8_exec i_alu8_exec (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_d(op_d), .op_r(op_r),
    .result(result), .wr_en(wr_en), .status(status)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] enc_rr(input logic [3:0] fn, input int d, input int r);
    logic [4:0] dd, rr;
    dd = d[4:0];
    rr = r[4:0];
    return {2'b00, fn, rr[4], dd, rr[3:0]};
  endfunction

  function automatic logic [15:0] enc_im(input logic [3:0] code, input int d, input logic [7:0] k);
    logic [3:0] dd;
    dd = d[3:0];
    return {code, k[7:4], dd, k[3:0]};
  endfunction

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // behavioural model: returns expected write and result, updates flags
  task automatic model(input logic [15:0] op, input int a, input int rb,
                       output bit ewr, output int eres, output string tag);
    int kind;  // 0 idle 1 add 2 sub 3 and 4 xor 5 or 6 copy
    bit carry_in, imm, wr;
    int b, ci, t, sv;
    kind = 0; carry_in = 0; imm = 0; wr = 0; tag = "R11 idle";
    casez (op)
      16'b000011??????????: begin kind = 1; wr = 1; tag = "R3 add"; end
      16'b000111??????????: begin kind = 1; wr = 1; carry_in = 1; tag = "R3 adc"; end
      16'b000110??????????: begin kind = 2; wr = 1; tag = "R4 sub"; end
      16'b000010??????????: begin kind = 2; wr = 1; carry_in = 1; tag = "R4 R6 sbc"; end
      16'b000101??????????: begin kind = 2; tag = "R5 cmp"; end
      16'b000001??????????: begin kind = 2; carry_in = 1; tag = "R5 R6 cmpc"; end
      16'b001000??????????: begin kind = 3; wr = 1; tag = "R8 and"; end
      16'b001001??????????: begin kind = 4; wr = 1; tag = "R8 xor"; end
      16'b001010??????????: begin kind = 5; wr = 1; tag = "R8 or"; end
      16'b001011??????????: begin kind = 6; wr = 1; tag = "R9 copy"; end
      16'b0011????????????: begin kind = 2; imm = 1; tag = "R5 R10 cmpi"; end
      16'b0100????????????: begin kind = 2; imm = 1; wr = 1; carry_in = 1; tag = "R4 R6 R10 sbci"; end
      16'b0101????????????: begin kind = 2; imm = 1; wr = 1; tag = "R4 R10 subi"; end
      16'b0110????????????: begin kind = 5; imm = 1; wr = 1; tag = "R8 R10 ori"; end
      16'b0111????????????: begin kind = 3; imm = 1; wr = 1; tag = "R8 R10 andi"; end
      default: ;
    endcase
    b  = imm ? int'({op[11:8], op[3:0]}) : rb;
    ci = (carry_in && mc) ? 1 : 0;
    eres = 0;
    case (kind)
      1: begin
        t = a + b + ci;
        eres = t % 256;
        mh = ((a % 16) + (b % 16) + ci) > 15;
        mc = t > 255;
        sv = sgn(a) + sgn(b) + ci;
        mv = (sv > 127) || (sv < -128);
        mz = (eres == 0);
      end
      2: begin
        t = a - b - ci;
        eres = (t + 256) % 256;
        mh = ((a % 16) - (b % 16) - ci) < 0;
        mc = t < 0;
        sv = sgn(a) - sgn(b) - ci;
        mv = (sv > 127) || (sv < -128);
        mz = (eres == 0) && (carry_in ? mz : 1'b1);
      end
      3, 4, 5: begin
        eres = (kind == 3) ? (a & b) : (kind == 4) ? (a ^ b) : (a | b);
        mv = 0;
        mz = (eres == 0);
      end
      6: eres = rb;
      default: ;
    endcase
    if (kind >= 1 && kind <= 5) begin
      mn = eres > 127;
      ms = mn ^ mv;
    end
    ewr = wr;
  endtask

  function automatic logic [5:0] mstat();
    return {mh, ms, mv, mn, mz, mc};
  endfunction

  // present one instruction at a falling edge, check after the next rising edge
  task automatic step(input logic [15:0] op, input logic [7:0] a, input logic [7:0] rb);
    bit ewr; int eres; string tag;
    opcode = op; op_d = a; op_r = rb;
    model(op, int'(a), int'(rb), ewr, eres, tag);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (wr_en !== ewr || status !== mstat() || (ewr && result !== eres[7:0])) begin
      fails++;
      $display("FAIL %s op=%h: wr=%b/%b result=%h/%h status=%b/%b",
               tag, op, wr_en, ewr, result, eres[7:0], status, mstat());
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    {mc, mz, mn, mv, ms, mh} = '0;
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (result !== 8'h00 || wr_en !== 1'b0 || status !== 6'h00) begin
      fails++;
      $display("FAIL R1 reset: result=%h/00 wr=%b/0 status=%b/000000", result, wr_en, status);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: output does not move before the rising edge
    opcode = enc_rr(4'b0011, 1, 2); op_d = 8'h11; op_r = 8'h22;
    #5;
    checks++;
    if (wr_en !== 1'b0) begin
      fails++;
      $display("FAIL R2 early update: wr=%b/0", wr_en);
    end
    @(negedge clk);
    step(enc_rr(4'b0011, 1, 2), 8'h11, 8'h22);
    checks++;  // R2: value held over a second cycle with the same inputs is still correct
    @(negedge clk);
    if (result !== 8'h33 || wr_en !== 1'b1) begin
      fails++;
      $display("FAIL R2 hold: result=%h/33 wr=%b/1", result, wr_en);
    end

    // R3 edges
    step(enc_rr(4'b0011, 0, 1), 8'h0F, 8'h01);   // half carry
    step(enc_rr(4'b0011, 0, 1), 8'h7F, 8'h01);   // overflow
    step(enc_rr(4'b0011, 0, 1), 8'hFF, 8'h01);   // carry, zero
    step(enc_rr(4'b0111, 0, 1), 8'h00, 8'h00);   // adc uses carry
    step(enc_rr(4'b0011, 0, 1), 8'h80, 8'h80);
    // R4 edges
    step(enc_rr(4'b0110, 3, 4), 8'h00, 8'h01);   // borrow
    step(enc_rr(4'b0010, 3, 4), 8'h05, 8'h04);   // sbc with borrow in -> 0, Z held low
    step(enc_rr(4'b0110, 3, 4), 8'h80, 8'h01);   // overflow
    step(enc_im(4'b0101, 2, 8'h10), 8'h10, 8'hAA); // subi to zero, op_r ignored
    // R6 chained zero: 16-bit compare of equal values
    step(enc_rr(4'b0101, 5, 6), 8'h34, 8'h34);   // cp low: Z=1
    step(enc_rr(4'b0001, 7, 8), 8'h12, 8'h12);   // cpc high: Z stays 1
    step(enc_rr(4'b0101, 5, 6), 8'h34, 8'h35);   // cp low differs: Z=0, C=1
    step(enc_rr(4'b0001, 7, 8), 8'h12, 8'h11);   // cpc result zero but Z must stay 0
    step(enc_im(4'b0100, 9, 8'h00), 8'h00, 8'h00); // sbci, zero result, Z still 0
    step(enc_im(4'b0011, 1, 8'h40), 8'h40, 8'h00); // cpi equal
    // R8 logic keeps C,H
    step(enc_rr(4'b0110, 1, 2), 8'h00, 8'h01);   // set C and H
    step(enc_rr(4'b1000, 1, 2), 8'hF0, 8'h0F);   // and -> 0
    step(enc_rr(4'b1001, 1, 2), 8'hF0, 8'h0F);
    step(enc_rr(4'b1010, 1, 2), 8'h80, 8'h01);
    step(enc_im(4'b0111, 1, 8'h3C), 8'hFF, 8'h00);
    step(enc_im(4'b0110, 1, 8'h81), 8'h00, 8'hFF);
    // R9 copy
    step(enc_rr(4'b1011, 1, 31), 8'h55, 8'hC3);
    // R11 foreign words
    step(16'h0000, 8'h12, 8'h34);
    step(16'h1000, 8'h12, 8'h12);
    step(16'h9403, 8'hFF, 8'hFF);
    step(16'hE0FF, 8'h01, 8'h01);

    for (int i = 0; i < 600; i++) begin
      logic [15:0] rop;
      rop = 16'($urandom);
      if (i % 4 != 0) rop[15] = 1'b0;
      step(rop, 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule